// File: doc/BRIEF.md
# Shared Counter Timebase with Event Flags

This block keeps one free-running counter that a group of capture/compare modules all read as their common time reference. Next to the counter it holds two small software-visible registers. A mode register sets whether the counter halts while the chip is idle, whether the last module acts as a watchdog, and whether a counter overflow may raise an interrupt. A control register holds the run bit, the overflow flag and one event flag for each module. The counter source is abstracted as a single tick-enable input. The block drives a combined enable, so the modules see exactly the cycles in which the timebase moves.

Each module sends a one-cycle pulse when it sees a match or a capture, and that pulse sets the module's flag. Flags are sticky. Hardware sets them and software clears them, by writing 0 to a flag bit of the control register. A flag can never be set by a write. The interrupt request combines the overflow flag, gated by its enable, with each module flag, gated by an enable input that comes from the module itself.

The register write port is a plain one-cycle strobe with no back-pressure. Every write with `wr_en` high is accepted on that clock edge. No data stream crosses the block boundary, so no valid/ready handshake is used.

Top module: `ctb_timebase`

## Requirements
- R1: The counter increases by one on every clock edge at which `cnt_en_o` is high, and holds its value otherwise. `cnt_en_o` is high only when the run bit is 1, `tick_en` is 1, and the block is not held by the idle stop.
- R2: A control write sets the run bit from `wr_data[6]`. With the run bit at 0 the counter does not change, whatever `tick_en` does.
- R3: When the counter steps from all ones to zero, the overflow flag (control bit 7) is set on that same edge.
- R4: In a control write (`wr_sel`=1), a 0 in bit 7 clears the overflow flag and a 0 in bit n (n = 0..4) clears module flag n. A 1 in any of these bits leaves the flag unchanged. A write never sets a flag, and bit 5 is ignored.
- R5: A high `mod_event[n]` during a cycle sets module flag n at the next edge. No other flag is touched.
- R6: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up at 1. This holds for the overflow flag and for every module flag.
- R7: `irq_o` = (overflow flag AND overflow enable) OR, for any n, (module flag n AND `mod_ie[n]`). It is combinational from the flags and `mod_ie`.
- R8: While the idle-stop bit is 1 and `idle` is high, the counter holds and `cnt_en_o` is 0. While the idle-stop bit is 0, `idle` has no effect.
- R9: The watchdog-enable mode bit is driven on `wdt_en_o` from the edge of the mode write onward.
- R10: Reset clears the counter, the run bit, the overflow flag, all module flags and all mode bits. `irq_o` is then 0.
- R11: A mode write (`wr_sel`=0) loads overflow enable from bit 0, watchdog enable from bit 1 and idle stop from bit 2. Bits 3 to 7 are ignored, and a mode write leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick from the selected clock source |
| idle | input | 1 | Chip idle indication |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 mode register, 1 control register |
| wr_data | input | 8 | Write data |
| mod_event | input | NMOD | Match/capture pulse, one bit per module |
| mod_ie | input | NMOD | Interrupt enable, one bit per module flag |
| count_o | output | CNT_W | Current counter value |
| cnt_en_o | output | 1 | Idle-gated count enable for this cycle |
| run_o | output | 1 | Run bit |
| ovf_flag_o | output | 1 | Overflow flag |
| mod_flag_o | output | NMOD | Module event flags |
| ovf_ie_o | output | 1 | Overflow interrupt enable (mode bit 0) |
| wdt_en_o | output | 1 | Watchdog enable for the last module (mode bit 1) |
| idle_stop_o | output | 1 | Idle stop (mode bit 2) |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter, run bit, flags and mode bits are registers. A stimulus applied in one cycle therefore appears at the ports right after the next rising edge: a tick, a write, a module pulse or a wrap takes exactly one edge. `cnt_en_o` and `irq_o` are combinational, so they follow `tick_en`, `idle` and `mod_ie` within the same cycle. The bench drives every input 1 ns after a rising edge and samples 1 ns after the edge that must carry the result. For the combinational outputs it samples 1 ns after changing the input, with no edge in between. Expected counts are tracked arithmetically, as the number of enabled ticks modulo 2^CNT_W. Expected flags are computed as bitwise AND/OR of the event pattern and the write data.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int REG_W           = 8;
  localparam int CTL_RUN_BIT     = 6;
  localparam int CTL_OVF_BIT     = 7;
  localparam int CTL_MAX_MOD     = 5;
  localparam int MODE_OVF_IE_BIT = 0;
  localparam int MODE_WDT_BIT    = 1;
  localparam int MODE_IDLE_BIT   = 2;

  typedef enum logic {
    SEL_MODE = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic idle_stop;
    logic wdt_en;
    logic ovf_ie;
  } mode_t;
endpackage

// File: rtl/ctb_counter.sv
module ctb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             idle,
  input  logic             idle_stop,
  output logic [CNT_W-1:0] count,
  output logic             cnt_en,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic             held;

  // idle hold only when the mode asks for it
  assign held   = idle_stop & idle;
  assign cnt_en = run & tick_en & ~held;
  assign wrap   = cnt_en & (count_q == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_q + ONE;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/ctb_mode_reg.sv
module ctb_mode_reg
  import ctb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic [2:0] wr_bits,
  output mode_t      mode
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q.ovf_ie    <= wr_bits[MODE_OVF_IE_BIT];
      mode_q.wdt_en    <= wr_bits[MODE_WDT_BIT];
      mode_q.idle_stop <= wr_bits[MODE_IDLE_BIT];
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/ctb_ctrl_reg.sv
module ctb_ctrl_reg
  import ctb_pkg::*;
#(
  parameter int NMOD = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_run,
  input  logic            wr_ovf_keep,
  input  logic [NMOD-1:0] wr_flag_keep,
  input  logic            wrap,
  input  logic [NMOD-1:0] mod_event,
  output logic            run,
  output logic            ovf_flag,
  output logic [NMOD-1:0] mod_flag
);
  logic            run_q;
  logic            ovf_q;
  logic [NMOD-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= wr_run;
    end
  end

  // hardware set has priority over a software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (wrap) begin
      ovf_q <= 1'b1;
    end else if (wr_ctrl && !wr_ovf_keep) begin
      ovf_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NMOD; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (mod_event[i]) begin
        flag_q[i] <= 1'b1;
      end else if (wr_ctrl && !wr_flag_keep[i]) begin
        flag_q[i] <= 1'b0;
      end
    end
  end

  assign run      = run_q;
  assign ovf_flag = ovf_q;
  assign mod_flag = flag_q;
endmodule

// File: rtl/ctb_irq.sv
module ctb_irq #(
  parameter int NMOD = 5
) (
  input  logic            ovf_flag,
  input  logic            ovf_ie,
  input  logic [NMOD-1:0] mod_flag,
  input  logic [NMOD-1:0] mod_ie,
  output logic            irq
);
  logic [NMOD-1:0] mod_req;

  assign mod_req = mod_flag & mod_ie;
  assign irq     = (ovf_flag & ovf_ie) | (|mod_req);
endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase
  import ctb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NMOD  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             idle,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [NMOD-1:0]  mod_event,
  input  logic [NMOD-1:0]  mod_ie,
  output logic [CNT_W-1:0] count_o,
  output logic             cnt_en_o,
  output logic             run_o,
  output logic             ovf_flag_o,
  output logic [NMOD-1:0]  mod_flag_o,
  output logic             ovf_ie_o,
  output logic             wdt_en_o,
  output logic             idle_stop_o,
  output logic             irq_o
);
  logic  wr_mode;
  logic  wr_ctrl;
  logic  wrap;
  logic  run;
  logic  ovf_flag;
  logic  cnt_en;
  mode_t mode;
  logic [NMOD-1:0]  mod_flag;
  logic [CNT_W-1:0] count;
  logic  unused_wr_bits;

  assign wr_mode        = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
  assign wr_ctrl        = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign unused_wr_bits = wr_data[5];

  ctb_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mode (wr_mode),
    .wr_bits (wr_data[2:0]),
    .mode    (mode)
  );

  ctb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick_en   (tick_en),
    .idle      (idle),
    .idle_stop (mode.idle_stop),
    .count     (count),
    .cnt_en    (cnt_en),
    .wrap      (wrap)
  );

  ctb_ctrl_reg #(.NMOD(NMOD)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wr_run       (wr_data[CTL_RUN_BIT]),
    .wr_ovf_keep  (wr_data[CTL_OVF_BIT]),
    .wr_flag_keep (wr_data[NMOD-1:0]),
    .wrap         (wrap),
    .mod_event    (mod_event),
    .run          (run),
    .ovf_flag     (ovf_flag),
    .mod_flag     (mod_flag)
  );

  ctb_irq #(.NMOD(NMOD)) u_irq (
    .ovf_flag (ovf_flag),
    .ovf_ie   (mode.ovf_ie),
    .mod_flag (mod_flag),
    .mod_ie   (mod_ie),
    .irq      (irq_o)
  );

  assign count_o     = count;
  assign cnt_en_o    = cnt_en;
  assign run_o       = run;
  assign ovf_flag_o  = ovf_flag;
  assign mod_flag_o  = mod_flag;
  assign ovf_ie_o    = mode.ovf_ie;
  assign wdt_en_o    = mode.wdt_en;
  assign idle_stop_o = mode.idle_stop;
endmodule

// File: rtl/ctb_timebase_chk.sv
module ctb_timebase_chk #(
  parameter int CNT_W = 16,
  parameter int NMOD  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic [NMOD-1:0]  mod_event,
  input logic [CNT_W-1:0] count_o,
  input logic             cnt_en_o,
  input logic             run_o,
  input logic             ovf_flag_o,
  input logic [NMOD-1:0]  mod_flag_o,
  input logic             ovf_ie_o,
  input logic             idle_stop_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_o |=> count_o == $past(count_o) + ONE);

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_o |=> $stable(count_o));

  // R2
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> $stable(count_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_stop_o) |=> $stable(count_o));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o && count_o == ALL_ONES) |=> ovf_flag_o);

  // R4
  ovf_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !$past(ovf_flag_o)) |-> $past(cnt_en_o && count_o == ALL_ONES));

  // R7
  irq_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && ovf_ie_o) |-> irq_o);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag_o && mod_flag_o == '0) |-> !irq_o);

  for (genvar i = 0; i < NMOD; i++) begin : g_mod
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_event[i] |=> mod_flag_o[i]);

    // R4
    flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_flag_o[i] && !$past(mod_flag_o[i])) |-> $past(mod_event[i]));
  end
endmodule

bind ctb_timebase ctb_timebase_chk #(.CNT_W(CNT_W), .NMOD(NMOD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle        (idle),
  .mod_event   (mod_event),
  .count_o     (count_o),
  .cnt_en_o    (cnt_en_o),
  .run_o       (run_o),
  .ovf_flag_o  (ovf_flag_o),
  .mod_flag_o  (mod_flag_o),
  .ovf_ie_o    (ovf_ie_o),
  .idle_stop_o (idle_stop_o),
  .irq_o       (irq_o)
);

// File: tb/ctb_timebase_test.sv
module ctb_timebase_test;
  localparam int CNT_W = 8;
  localparam int NMOD  = 5;
  localparam int MODV  = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b0;
  logic             idle = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [NMOD-1:0]  mod_event = '0;
  logic [NMOD-1:0]  mod_ie = '0;
  logic [CNT_W-1:0] count_o;
  logic             cnt_en_o;
  logic             run_o;
  logic             ovf_flag_o;
  logic [NMOD-1:0]  mod_flag_o;
  logic             ovf_ie_o;
  logic             wdt_en_o;
  logic             idle_stop_o;
  logic             irq_o;

  int n_chk = 0;
  int n_err = 0;
  int exp_cnt;

  always #5 clk = ~clk;

  ctb_timebase #(.CNT_W(CNT_W), .NMOD(NMOD)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idle(idle),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mod_event(mod_event), .mod_ie(mod_ie),
    .count_o(count_o), .cnt_en_o(cnt_en_o), .run_o(run_o),
    .ovf_flag_o(ovf_flag_o), .mod_flag_o(mod_flag_o),
    .ovf_ie_o(ovf_ie_o), .wdt_en_o(wdt_en_o),
    .idle_stop_o(idle_stop_o), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_en = 1'b0; idle = 1'b0; wr_en = 1'b0;
    mod_event = '0; mod_ie = '0;
    step(); step();
    rst_n = 1'b1;
    exp_cnt = 0;
  endtask

  task automatic chk_reset_state(input string req);
    chk(req, {24'd0, count_o}, 0);
    chk(req, {run_o, ovf_flag_o, mod_flag_o}, 0);
    chk(req, {ovf_ie_o, wdt_en_o, idle_stop_o, irq_o}, 0);
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset();
    chk_reset_state("R10");

    // R11 / R9 mode register: every write value
    for (int v = 0; v < 256; v++) begin
      wr(1'b0, 8'(v));
      chk("R11", {ovf_ie_o, idle_stop_o}, {v[0], v[2]});
      chk("R9", wdt_en_o, v[1]);
      chk("R11 ctrl untouched", {run_o, ovf_flag_o, mod_flag_o}, 0);
    end

    // R1 tick patterns: tick every k-th cycle
    for (int k = 1; k <= 4; k++) begin
      do_reset();
      wr(1'b1, 8'h40);
      for (int c = 0; c < 40; c++) begin
        tick_en = (c % k == 0);
        #1;
        chk("R1 enable", cnt_en_o, tick_en);
        step();
        if (tick_en) exp_cnt++;
        chk("R1 count", count_o, exp_cnt % MODV);
      end
    end

    // R2 clearing run stops the counter (write edge still counts)
    tick_en = 1'b1;
    wr(1'b1, 8'h00);
    exp_cnt++;
    for (int c = 0; c < 5; c++) begin
      step();
      chk("R2 stopped", count_o, exp_cnt % MODV);
    end
    chk("R2 enable low", cnt_en_o, 0);
    tick_en = 1'b0;

    // R8 idle stop
    do_reset();
    wr(1'b0, 8'h04);
    wr(1'b1, 8'h40);
    tick_en = 1'b1; idle = 1'b1;
    for (int c = 0; c < 5; c++) begin
      step();
      chk("R8 idle hold", count_o, exp_cnt);
    end
    chk("R8 enable gated", cnt_en_o, 0);
    idle = 1'b0;
    for (int c = 0; c < 3; c++) step();
    exp_cnt += 3;
    chk("R8 resume", count_o, exp_cnt);
    idle = 1'b1;
    wr(1'b0, 8'h00);
    for (int c = 0; c < 4; c++) step();
    exp_cnt += 4;
    chk("R8 idle ignored", count_o, exp_cnt);
    idle = 1'b0; tick_en = 1'b0;

    // R3 wrap sets overflow
    do_reset();
    wr(1'b1, 8'h40);
    tick_en = 1'b1;
    for (int c = 0; c < MODV - 1; c++) step();
    chk("R3 before wrap", {ovf_flag_o, count_o}, {1'b0, 8'hFF});
    step();
    chk("R3 after wrap", {ovf_flag_o, count_o}, {1'b1, 8'h00});
    chk("R7 ovf masked", irq_o, 0);
    wr(1'b0, 8'h01);
    exp_cnt = 1;
    tick_en = 1'b0;
    chk("R7 ovf irq", irq_o, 1);
    // R4 a write of 1 keeps, a write of 0 clears
    wr(1'b1, 8'hFF);
    chk("R4 keep ovf", {run_o, ovf_flag_o, mod_flag_o}, {1'b1, 1'b1, 5'h00});
    wr(1'b1, 8'h40);
    chk("R4 clear ovf", {ovf_flag_o, irq_o}, 0);
    wr(1'b1, 8'hC0);
    chk("R4 no sw set", ovf_flag_o, 0);
    // R6 wrap and clear in one cycle
    tick_en = 1'b1;
    for (int c = 0; c < MODV - 2; c++) step();
    chk("R6 pre", count_o, 8'hFF);
    wr(1'b1, 8'h40);
    tick_en = 1'b0;
    chk("R6 ovf wins", {ovf_flag_o, count_o}, {1'b1, 8'h00});

    // R5 / R4 / R7 flag patterns
    do_reset();
    for (int p = 1; p < 32; p++) begin
      mod_event = 5'(p);
      step();
      mod_event = '0;
      chk("R5 flags", mod_flag_o, p);
      for (int ie = 0; ie < 32; ie++) begin
        mod_ie = 5'(ie);
        #1;
        chk("R7 irq", irq_o, ((p & ie) != 0));
      end
      mod_ie = '0;
      wr(1'b1, 8'h1F);
      chk("R4 keep flags", mod_flag_o, p);
      wr(1'b1, 8'((p * 7) & 31));
      chk("R4 partial clear", mod_flag_o, p & ((p * 7) & 31));
      wr(1'b1, 8'h20);
      chk("R4 clear all", mod_flag_o, 0);
    end

    // R6 event and clear in the same cycle
    for (int n = 0; n < NMOD; n++) begin
      mod_event = 5'(1 << n);
      step();
      mod_event = 5'(1 << n);
      wr(1'b1, 8'h00);
      mod_event = '0;
      chk("R6 flag wins", mod_flag_o, 1 << n);
      wr(1'b1, 8'h00);
      chk("R6 cleared", mod_flag_o, 0);
    end

    // R10 reset from a dirty state
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h40);
    mod_event = '1;
    tick_en = 1'b1;
    step();
    do_reset();
    chk_reset_state("R10 dirty");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule